// File: doc/BRIEF.md
# Double-Buffered Edge-Aligned PWM Channel

This block is one PWM timer channel. A free-running up-counter restarts at a programmable limit, and the single output is high while the count is below a programmable match value. Software sees two copies of the limit and the match value. It writes a staging copy. The counter and the comparator use a separate operational copy. The operational copy is refreshed from staging only at safe points, so a period that is already running never sees a half-changed setting.

Software controls the channel through one write port and one registered read port. The write port reaches the limit, the match value, the counter and a control word. The control word has a run bit and an update-hold bit. While the channel runs, new staging values take effect on the cycle the counter restarts from zero. If the hold bit is set, they wait until the channel is stopped. While the channel is stopped, writes take effect at once. The counter itself can be loaded only while the channel is stopped.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After synchronous reset, the counter, the limit, the match value and the control word all read back 0, and `pwm_out` is low.
- R2: While running, the counter advances by one each clock. On the clock after the counter equals the operational limit, it reads 0, which gives a period of limit+1 cycles.
- R3: While running, `pwm_out` is high exactly when the counter is below the operational match value. A match of 0 keeps the output low, and a match above the limit keeps it high.
- R4: The address map is 0 = limit, 1 = match, 2 = counter, 3 = control (bit 0 run, bit 1 update-hold). A read returns, one cycle later, the value held at the clock edge where `rd_addr` was sampled. Limit and match read back the staging value last written.
- R5: A limit or match write made while running without hold has no effect on the period in progress. It governs the output from the first cycle the counter is 0 after the next wrap.
- R6: While running with update-hold set, the operational limit and match stay unchanged across wraps. After the channel is stopped, the last written staging values are in force.
- R7: A limit or match write made while stopped is in force from the next cycle, with no wrap needed.
- R8: A counter write is ignored while running and loaded while stopped.
- R9: Clearing the run bit freezes the counter at the value it reached on that edge and forces `pwm_out` low until the channel runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select (see R4) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read register select (see R4) |
| rd_data | output | CNT_W | Registered read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest state to reach from the ports is the one where staging and operational values differ while the counter runs. The operational copy cannot be read, so the difference shows only in the shape of the output. The bench starts the channel from a known counter value, writes a new limit or match a fixed number of cycles into a period, and follows the output cycle by cycle. This shows the old period finishing and the new one starting at the wrap. With update-hold set, the old shape must persist over several wraps and change only after a stop and restart. A sweep over small limit and match pairs checks the duty pattern arithmetically, including the zero-match and above-limit cases.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    ADDR_LIM = 2'd0,
    ADDR_MAT = 2'd1,
    ADDR_CNT = 2'd2,
    ADDR_CTL = 2'd3
  } reg_addr_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_HOLD_BIT = 1;
  localparam int NUM_SLOTS    = 2;  // slot 0 = limit, slot 1 = match
endpackage

// File: rtl/pwm_dbuf_slot.sv
module pwm_dbuf_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         run,
  input  logic         hold,
  input  logic         wrap,
  output logic [W-1:0] stg,
  output logic [W-1:0] op,
  output logic [W-1:0] op_nxt
);
  logic [W-1:0] stg_nxt;

  always_comb begin
    stg_nxt = wr_hit ? wr_data : stg;
    if (!run)
      op_nxt = stg_nxt;
    else if (wrap && !hold)
      op_nxt = stg_nxt;
    else
      op_nxt = op;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
      op  <= '0;
    end else begin
      stg <= stg_nxt;
      op  <= op_nxt;
    end
  end

  // R6: hold keeps the operational copy steady while running
  assert_hold_keeps_op_R6: assert property (@(posedge clk) disable iff (rst)
    (run && hold) |=> (op == $past(op)));

  // R7: a stopped channel leaves staging and operational copies equal
  assert_stopped_op_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (op == stg));

  // R5: while running without a wrap, staging writes do not reach op
  assert_no_midperiod_load_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> (op == $past(op)));
endmodule

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_addr,
  input  logic [W-1:0]                  wr_data,
  input  logic                          wrap,
  output logic                          run,
  output logic                          run_nxt,
  output logic                          hold,
  output logic [NUM_SLOTS-1:0][W-1:0]   stg,
  output logic [NUM_SLOTS-1:0][W-1:0]   op,
  output logic [NUM_SLOTS-1:0][W-1:0]   op_nxt
);
  logic ctl_hit;
  logic hold_nxt;

  assign ctl_hit  = wr_en && (wr_addr == ADDR_CTL);
  assign run_nxt  = ctl_hit ? wr_data[CTL_RUN_BIT]  : run;
  assign hold_nxt = ctl_hit ? wr_data[CTL_HOLD_BIT] : hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      hold <= 1'b0;
    end else begin
      run  <= run_nxt;
      hold <= hold_nxt;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [1:0] SLOT_ADDR = 2'(g);
    logic hit;
    assign hit = wr_en && (wr_addr == SLOT_ADDR);
    pwm_dbuf_slot #(.W(W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (hit),
      .wr_data (wr_data),
      .run     (run),
      .hold    (hold),
      .wrap    (wrap),
      .stg     (stg[g]),
      .op      (op[g]),
      .op_nxt  (op_nxt[g])
    );
  end
endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] lim_op,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  assign wrap = run && (cnt == lim_op);

  always_comb begin
    if (run)
      cnt_nxt = wrap ? '0 : cnt + W'(1);
    else if (wr_hit)
      cnt_nxt = wr_data;
    else
      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // R2: restart from zero after reaching the limit
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  // R2: single-step advance between wraps
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> (cnt == $past(cnt) + W'(1)));

  // R8: writes during running never load the counter
  assert_run_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (run && wr_hit && !wrap && (wr_data != cnt + W'(1))) |=> (cnt != $past(wr_data)));

  // R9: stopped counter is frozen without a write
  assert_stopped_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_hit) |=> $stable(cnt));
endmodule

// File: rtl/pwm_dbuf_out.sv
module pwm_dbuf_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_nxt,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] mat_nxt,
  output logic         pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run_nxt && (cnt_nxt < mat_nxt);
  end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out
);
  localparam int SLOT_LIM = 0;
  localparam int SLOT_MAT = 1;

  logic                            run, run_nxt, hold, wrap;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] stg, op, op_nxt;
  logic [CNT_W-1:0]                cnt, cnt_nxt;
  logic                            cnt_hit;
  logic [CNT_W-1:0]                rd_mux;

  assign cnt_hit = wr_en && (wr_addr == ADDR_CNT);

  pwm_dbuf_regs #(.W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wrap    (wrap),
    .run     (run),
    .run_nxt (run_nxt),
    .hold    (hold),
    .stg     (stg),
    .op      (op),
    .op_nxt  (op_nxt)
  );

  pwm_dbuf_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .wr_hit  (cnt_hit),
    .wr_data (wr_data),
    .lim_op  (op[SLOT_LIM]),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  pwm_dbuf_out #(.W(CNT_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .run_nxt (run_nxt),
    .cnt_nxt (cnt_nxt),
    .mat_nxt (op_nxt[SLOT_MAT]),
    .pwm_q   (pwm_out)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_LIM: rd_mux = stg[SLOT_LIM];
      ADDR_MAT: rd_mux = stg[SLOT_MAT];
      ADDR_CNT: rd_mux = cnt;
      default:  rd_mux = CNT_W'({hold, run});
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R3: output level agrees with the count and the operational match
  assert_out_level_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pwm_out == (cnt < op[SLOT_MAT])));

  // R9: a stopped channel drives the output low
  assert_stopped_low_R9: assert property (@(posedge clk) disable iff (rst)
    !run |-> !pwm_out);

  // R1: reset leaves output and control cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pwm_out && !run && !hold && (cnt == '0)));
endmodule

// File: tb/pwm_dbuf_chan_tb.sv
module pwm_dbuf_chan_tb;
  localparam int W = 8;
  localparam logic [1:0] A_LIM = 2'd0;
  localparam logic [1:0] A_MAT = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         pwm_out;

  int total = 0;
  int bad = 0;
  int errs;
  int c;
  int lim;
  logic [W-1:0] v;

  always #2 clk = ~clk;

  pwm_dbuf_chan #(.CNT_W(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] val);
    rd_addr = a;
    @(negedge clk);
    val = rd_data;
  endtask

  // start from stopped with counter 0 and given limit/match
  task automatic setup(input int l, input int m, input int ctl);
    wr(A_CTL, 0);
    wr(A_CNT, 0);
    wr(A_LIM, l);
    wr(A_MAT, m);
    wr(A_CTL, ctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(pwm_out == 1'b0, "R1 pwm", int'(pwm_out), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == '0, "R1 readback", int'(v), 0);
    end

    // R2 R3 R7: sweep limits and matches, written while stopped
    for (int l = 0; l < 8; l++) begin
      for (int m = 0; m <= 9; m++) begin
        setup(l, m, 1);
        errs = 0;
        for (int i = 0; i < 2 * (l + 1); i++) begin
          if (pwm_out != ((i % (l + 1)) < m)) errs++;
          @(negedge clk);
        end
        chk(errs == 0, "R2/R3 sweep mismatches", errs, 0);
      end
    end

    // R5: limit write during a running period waits for the wrap
    setup(3, 2, 1);
    @(negedge clk);         // counter now 1
    wr(A_LIM, 5);           // counter now 2, old limit still in force
    c = 2; lim = 3; errs = 0;
    for (int k = 0; k < 9; k++) begin
      if (pwm_out != (c < 2)) errs++;
      if (c == lim) begin c = 0; lim = 5; end else c++;
      @(negedge clk);
    end
    chk(errs == 0, "R5 deferred load mismatches", errs, 0);
    rd(A_LIM, v);
    chk(v == 8'd5, "R4 limit staging readback", int'(v), 5);

    // R6: hold keeps old values across wraps
    setup(3, 2, 3);
    wr(A_LIM, 1);           // counter 1
    wr(A_MAT, 1);           // counter 2
    c = 2; errs = 0;
    for (int k = 0; k < 10; k++) begin
      if (pwm_out != (c < 2)) errs++;
      c = (c == 3) ? 0 : c + 1;
      @(negedge clk);
    end
    chk(errs == 0, "R6 held values mismatches", errs, 0);
    rd(A_CTL, v);
    chk(v == 8'd3, "R4 control readback", int'(v), 3);
    wr(A_CTL, 2);           // stop, hold still set
    chk(pwm_out == 1'b0, "R9 stopped low", int'(pwm_out), 0);
    wr(A_CNT, 0);
    wr(A_CTL, 3);
    errs = 0;
    for (int i = 0; i < 6; i++) begin
      if (pwm_out != ((i % 2) < 1)) errs++;
      @(negedge clk);
    end
    chk(errs == 0, "R6 refreshed after stop mismatches", errs, 0);

    // R8 R9: counter write while running, freeze on stop
    setup(5, 3, 1);         // counter 0
    wr(A_CNT, 7);           // ignored, counter 1
    wr(A_CTL, 0);           // last running edge, counter 2
    chk(pwm_out == 1'b0, "R9 low after stop", int'(pwm_out), 0);
    rd(A_CNT, v);
    chk(v == 8'd2, "R8 running write ignored", int'(v), 2);
    repeat (5) @(negedge clk);
    rd(A_CNT, v);
    chk(v == 8'd2, "R9 counter frozen", int'(v), 2);
    chk(pwm_out == 1'b0, "R9 still low", int'(pwm_out), 0);
    wr(A_CNT, 4);
    rd(A_CNT, v);
    chk(v == 8'd4, "R8 stopped write loads", int'(v), 4);
    rd(A_MAT, v);
    chk(v == 8'd3, "R4 match readback", int'(v), 3);

    // R7: match written while stopped is used immediately on run
    wr(A_MAT, 5);
    wr(A_CTL, 1);
    c = 4; errs = 0;
    for (int k = 0; k < 8; k++) begin
      if (pwm_out != (c < 5)) errs++;
      c = (c == 5) ? 0 : c + 1;
      @(negedge clk);
    end
    chk(errs == 0, "R7 immediate match mismatches", errs, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule